// File: doc/BRIEF.md
# Pipelined Fractional Complex Multiplier

This block multiplies two complex numbers held in Q1.15 fractional two's complement. Each operand has a 16-bit real part and a 16-bit imaginary part. The result is the full-precision complex product in Q1.31, with a 32-bit real part and a 32-bit imaginary part. The block is fully pipelined. It accepts one operand pair on every clock and returns each result a fixed time later, together with a matching valid flag.

The datapath forms four cross products. Each one is realigned to Q1.31. Two saturating adder/subtractors then combine them into the two output parts. A control input selects the product with the conjugate of operand B. In that mode the real combiner adds and the imaginary combiner subtracts.

The single unrepresentable case, -1.0 times -1.0, is caught in each cross product and clamped to the largest positive value. A registered growth flag reports when either output part has a magnitude of at least one half. A block-exponent controller can use this flag to decide whether to scale the next FFT pass.

Top module: `cplx_frac_mul`

## Requirements
- R1: With `conj_b` low, `prod_re` equals ar*br - ai*bi in Q1.31, where each Q1.15 product is doubled to Q1.31.
- R2: With `conj_b` low, `prod_im` equals ar*bi + ai*br in Q1.31.
- R3: With `conj_b` high, `prod_re` equals ar*br + ai*bi and `prod_im` equals ai*br - ar*bi.
- R4: Any cross product whose two factors are both 16'h8000 is replaced by 32'h7FFFFFFF before combining. With all four inputs at 16'h8000 and `conj_b` low, the outputs are `prod_re` = 0 and `prod_im` = 32'h7FFFFFFF.
- R5: A combined sum outside the signed 32-bit range is clamped: to 32'h7FFFFFFF if it is too large, and to 32'h80000000 if it is too small.
- R6: Inputs sampled with `in_valid` high at a rising edge produce their result, with `out_valid` high, after the next rising edge. The result is therefore registered by the second edge, counting the capture edge. `out_valid` is low for every edge at which `in_valid` was low.
- R7: Operand pairs presented on consecutive cycles each produce their own result on consecutive cycles.
- R8: `grow` is high together with each result exactly when bit 31 differs from bit 30 in `prod_re` or in `prod_im`.
- R9: While `rst_n` is low, and for the first two edges after it rises, `out_valid` is low.
- R10: `prod_re`, `prod_im` and `grow` keep their last values whenever no valid result is produced.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously outside the block |
| in_valid | input | 1 | Operand pair on the inputs is valid |
| conj_b | input | 1 | Use the conjugate of operand B |
| a_re | input | 16 | Operand A real part, Q1.15 |
| a_im | input | 16 | Operand A imaginary part, Q1.15 |
| b_re | input | 16 | Operand B real part, Q1.15 |
| b_im | input | 16 | Operand B imaginary part, Q1.15 |
| out_valid | output | 1 | Result on the outputs is valid |
| prod_re | output | 32 | Product real part, Q1.31 |
| prod_im | output | 32 | Product imaginary part, Q1.31 |
| grow | output | 1 | Magnitude of either part is at least one half |

## Verification
The assertions check on every cycle that the valid pipeline has exactly the stated latency, that `out_valid` is low right after reset, and that the outputs hold when no result is produced. They also check that the growth flag agrees with the top bits of the outputs and that the all-minus-one input gives the trapped values.

The arithmetic itself can only be shown by the bench's scenarios. These cover random operands in both conjugation modes, every part at -1.0, sums that saturate in either direction, and back-to-back streams mixed with idle gaps. Each result is compared against a wide-integer model.

// File: rtl/cfm_pkg.sv
package cfm_pkg;
  // Operation selected for one adder/subtractor
  typedef enum logic {
    CMB_ADD = 1'b0,
    CMB_SUB = 1'b1
  } cmb_op_e;
endpackage

// File: rtl/cfm_partial.sv
// One signed fractional cross product, realigned to Q1.(2W-1), with the
// -1 * -1 overflow clamped to the largest positive value.
module cfm_partial #(
  parameter int W = 16
) (
  input  logic [W-1:0]   op_x,
  input  logic [W-1:0]   op_y,
  output logic [2*W-1:0] prod
);
  localparam int PW = 2 * W;
  localparam logic [PW-1:0] POS_MAX = {1'b0, {(PW-1){1'b1}}};

  logic signed [PW-1:0] raw;
  logic                 trap;

  always_comb begin
    raw  = $signed({{W{op_x[W-1]}}, op_x}) * $signed({{W{op_y[W-1]}}, op_y});
    // Only (-1)*(-1) yields a raw product whose two top bits disagree
    trap = raw[PW-1] ^ raw[PW-2];
    prod = trap ? POS_MAX : {raw[PW-2:0], 1'b0};
  end
endmodule

// File: rtl/cfm_combine.sv
// Saturating adder/subtractor for two Q1.(W-1) values.
module cfm_combine
  import cfm_pkg::*;
#(
  parameter int W = 32
) (
  input  logic [W-1:0] in_x,
  input  logic [W-1:0] in_y,
  input  cmb_op_e      op,
  output logic [W-1:0] res
);
  localparam logic [W-1:0] POS_MAX = {1'b0, {(W-1){1'b1}}};
  localparam logic [W-1:0] NEG_MIN = {1'b1, {(W-1){1'b0}}};

  logic [W:0] wide;

  always_comb begin
    if (op == CMB_SUB) wide = {in_x[W-1], in_x} - {in_y[W-1], in_y};
    else               wide = {in_x[W-1], in_x} + {in_y[W-1], in_y};
    if (wide[W] != wide[W-1]) res = wide[W] ? NEG_MIN : POS_MAX;
    else                      res = wide[W-1:0];
  end
endmodule

// File: rtl/cplx_frac_mul.sv
module cplx_frac_mul
  import cfm_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  in_valid,
  input  logic                  conj_b,
  input  logic [DATA_W-1:0]     a_re,
  input  logic [DATA_W-1:0]     a_im,
  input  logic [DATA_W-1:0]     b_re,
  input  logic [DATA_W-1:0]     b_im,
  output logic                  out_valid,
  output logic [2*DATA_W-1:0]   prod_re,
  output logic [2*DATA_W-1:0]   prod_im,
  output logic                  grow
);
  localparam int PW    = 2 * DATA_W;
  localparam int N_MUL = 4;

  // Stage 1: operand registers
  logic              s1_valid;
  logic              s1_conj;
  logic [DATA_W-1:0] s1_ar, s1_ai, s1_br, s1_bi;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) s1_valid <= 1'b0;
    else        s1_valid <= in_valid;
  end

  always_ff @(posedge clk) begin
    if (in_valid) begin
      s1_conj <= conj_b;
      s1_ar   <= a_re;
      s1_ai   <= a_im;
      s1_br   <= b_re;
      s1_bi   <= b_im;
    end
  end

  // Cross products: 0 ar*br, 1 ai*bi, 2 ar*bi, 3 ai*br
  logic [DATA_W-1:0] mul_x [N_MUL];
  logic [DATA_W-1:0] mul_y [N_MUL];
  logic [PW-1:0]     pp    [N_MUL];

  always_comb begin
    mul_x[0] = s1_ar;  mul_y[0] = s1_br;
    mul_x[1] = s1_ai;  mul_y[1] = s1_bi;
    mul_x[2] = s1_ar;  mul_y[2] = s1_bi;
    mul_x[3] = s1_ai;  mul_y[3] = s1_br;
  end

  for (genvar g = 0; g < N_MUL; g++) begin : g_mul
    cfm_partial #(.W(DATA_W)) i_partial (
      .op_x (mul_x[g]),
      .op_y (mul_y[g]),
      .prod (pp[g])
    );
  end

  // Combiners: conjugation flips both operations
  cmb_op_e       re_op, im_op;
  logic [PW-1:0] re_d, im_d;
  logic          grow_d;

  always_comb begin
    re_op = s1_conj ? CMB_ADD : CMB_SUB;
    im_op = s1_conj ? CMB_SUB : CMB_ADD;
  end

  cfm_combine #(.W(PW)) i_comb_re (
    .in_x (pp[0]),
    .in_y (pp[1]),
    .op   (re_op),
    .res  (re_d)
  );

  cfm_combine #(.W(PW)) i_comb_im (
    .in_x (pp[3]),
    .in_y (pp[2]),
    .op   (im_op),
    .res  (im_d)
  );

  always_comb begin
    grow_d = (re_d[PW-1] ^ re_d[PW-2]) | (im_d[PW-1] ^ im_d[PW-2]);
  end

  // Stage 2: result registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) out_valid <= 1'b0;
    else        out_valid <= s1_valid;
  end

  always_ff @(posedge clk) begin
    if (s1_valid) begin
      prod_re <= re_d;
      prod_im <= im_d;
      grow    <= grow_d;
    end
  end
endmodule

// File: rtl/cfm_checker.sv
module cfm_checker #(
  parameter int DATA_W = 16
) (
  input logic                clk,
  input logic                rst_n,
  input logic                in_valid,
  input logic                conj_b,
  input logic [DATA_W-1:0]   a_re,
  input logic [DATA_W-1:0]   a_im,
  input logic [DATA_W-1:0]   b_re,
  input logic [DATA_W-1:0]   b_im,
  input logic                out_valid,
  input logic [2*DATA_W-1:0] prod_re,
  input logic [2*DATA_W-1:0] prod_im,
  input logic                grow
);
  localparam int PW = 2 * DATA_W;
  localparam logic [DATA_W-1:0] NEG_ONE = {1'b1, {(DATA_W-1){1'b0}}};
  localparam logic [PW-1:0]     POS_MAX = {1'b0, {(PW-1){1'b1}}};

  // Edges seen since reset release, saturating at 3
  logic [1:0] since_rst;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)               since_rst <= 2'd0;
    else if (since_rst != 2'd3) since_rst <= since_rst + 2'd1;
  end

  logic all_neg_one;
  always_comb begin
    all_neg_one = in_valid && !conj_b && a_re == NEG_ONE && a_im == NEG_ONE
                  && b_re == NEG_ONE && b_im == NEG_ONE;
  end

  assert_latency_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (since_rst >= 2'd2) |-> (out_valid == $past(in_valid, 2)));

  assert_reset_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (since_rst < 2'd2) |-> !out_valid);

  assert_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (since_rst >= 2'd2 && !$past(in_valid, 2)) |->
      ($stable(prod_re) && $stable(prod_im) && $stable(grow)));

  assert_grow_R8: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (grow == ((prod_re[PW-1] ^ prod_re[PW-2]) | (prod_im[PW-1] ^ prod_im[PW-2]))));

  assert_trap_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (since_rst >= 2'd2 && $past(all_neg_one, 2)) |->
      (prod_re == '0 && prod_im == POS_MAX));
endmodule

bind cplx_frac_mul cfm_checker #(.DATA_W(DATA_W)) i_cfm_checker (
  .clk       (clk),
  .rst_n     (rst_n),
  .in_valid  (in_valid),
  .conj_b    (conj_b),
  .a_re      (a_re),
  .a_im      (a_im),
  .b_re      (b_re),
  .b_im      (b_im),
  .out_valid (out_valid),
  .prod_re   (prod_re),
  .prod_im   (prod_im),
  .grow      (grow)
);

// File: tb/test_cplx_frac_mul.sv
module test_cplx_frac_mul;
  logic        clk;
  logic        rst_n;
  logic        in_valid;
  logic        conj_b;
  logic [15:0] a_re, a_im, b_re, b_im;
  logic        out_valid;
  logic [31:0] prod_re, prod_im;
  logic        grow;

  int errors = 0;
  int checks = 0;
  bit done   = 0;

  cplx_frac_mul i_cplx_frac_mul (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .conj_b(conj_b),
    .a_re(a_re), .a_im(a_im), .b_re(b_re), .b_im(b_im),
    .out_valid(out_valid), .prod_re(prod_re), .prod_im(prod_im), .grow(grow)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  typedef struct {
    bit          v;
    logic [31:0] re;
    logic [31:0] im;
    bit          g;
    string       tre;
    string       tim;
  } exp_t;

  exp_t d1, d2;
  bit          have_last = 0;
  logic [31:0] last_re, last_im;
  bit          last_g;

  localparam longint QMAX = 64'sd2147483647;
  localparam longint QMIN = -64'sd2147483648;

  function automatic longint xprod(logic [15:0] x, logic [15:0] y);
    longint p = longint'($signed(x)) * longint'($signed(y)) * 2;
    if (p > QMAX) p = QMAX;
    return p;
  endfunction

  function automatic longint clampq(longint v);
    if (v > QMAX) return QMAX;
    if (v < QMIN) return QMIN;
    return v;
  endfunction

  function automatic bit big(longint v);
    return (v >= 64'sd1073741824) || (v < -64'sd1073741824);
  endfunction

  task automatic chk(bit ok, string req, string what, longint act, longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic compare();
    chk(out_valid == d2.v, "R6", "out_valid", longint'(out_valid), longint'(d2.v));
    if (d2.v) begin
      chk(prod_re == d2.re, d2.tre, "prod_re", longint'(prod_re), longint'(d2.re));
      chk(prod_im == d2.im, d2.tim, "prod_im", longint'(prod_im), longint'(d2.im));
      chk(grow == d2.g, "R8", "grow", longint'(grow), longint'(d2.g));
      have_last = 1; last_re = d2.re; last_im = d2.im; last_g = d2.g;
    end else if (have_last) begin
      chk(prod_re == last_re && prod_im == last_im && grow == last_g, "R10",
          "hold prod_re", longint'(prod_re), longint'(last_re));
    end
  endtask

  // One cycle: check the result of two cycles ago, then drive new inputs
  task automatic step(bit v, bit cj, logic [15:0] ar, logic [15:0] ai,
                      logic [15:0] br, logic [15:0] bi, string tag);
    exp_t e;
    longint p0, p1, p2, p3, r, i;
    bit trap;
    @(negedge clk);
    compare();
    p0 = xprod(ar, br); p1 = xprod(ai, bi);
    p2 = xprod(ar, bi); p3 = xprod(ai, br);
    r = cj ? p0 + p1 : p0 - p1;
    i = cj ? p3 - p2 : p2 + p3;
    trap = (ar == 16'h8000 && (br == 16'h8000 || bi == 16'h8000)) ||
           (ai == 16'h8000 && (br == 16'h8000 || bi == 16'h8000));
    e.v  = v;
    e.re = 32'(clampq(r));
    e.im = 32'(clampq(i));
    e.g  = big(clampq(r)) || big(clampq(i));
    e.tre = cj ? "R3" : trap ? "R4" : (r != clampq(r)) ? "R5" : "R1";
    e.tim = cj ? "R3" : trap ? "R4" : (i != clampq(i)) ? "R5" : "R2";
    if (tag != "") begin e.tre = tag; e.tim = tag; end
    d2 = d1;
    d1 = e;
    in_valid = v; conj_b = cj;
    a_re = ar; a_im = ai; b_re = br; b_im = bi;
  endtask

  function automatic logic [15:0] pick();
    case ($urandom % 6)
      0: return 16'h8000;
      1: return 16'h7FFF;
      2: return 16'h0000;
      default: return 16'($urandom);
    endcase
  endfunction

  initial begin
    void'($urandom(32'd4711));
    rst_n = 1'b0; in_valid = 1'b0; conj_b = 1'b0;
    a_re = '0; a_im = '0; b_re = '0; b_im = '0;
    d1.v = 0; d2.v = 0;
    repeat (3) @(negedge clk);
    chk(out_valid == 1'b0, "R9", "out_valid in reset", longint'(out_valid), 0);
    rst_n = 1'b1;
    // Directed corners: trap with and without conjugation (R4, R3)
    step(1, 0, 16'h8000, 16'h8000, 16'h8000, 16'h8000, "R4");
    step(1, 1, 16'h8000, 16'h8000, 16'h8000, 16'h8000, "R3");
    // Negative and positive saturation (R5)
    step(1, 0, 16'h8000, 16'h7FFF, 16'h7FFF, 16'h7FFF, "R5");
    step(1, 0, 16'h7FFF, 16'h7FFF, 16'h7FFF, 16'h7FFF, "R5");
    // Zero result, grow low (R8), then idle to show hold (R10)
    step(1, 0, 16'h0000, 16'h0000, 16'h1234, 16'h4321, "");
    step(0, 0, 16'h7FFF, 16'h7FFF, 16'h7FFF, 16'h7FFF, "");
    step(0, 1, 16'h8000, 16'h1111, 16'h2222, 16'h3333, "");
    // Single parts at -1.0 against mixed values
    step(1, 0, 16'h8000, 16'h4000, 16'hC000, 16'h8000, "");
    step(1, 1, 16'h2000, 16'h8000, 16'h8000, 16'h0001, "");
    // Back-to-back random stream, R7 (no gaps)
    for (int k = 0; k < 200; k++)
      step(1, 1'($urandom), pick(), pick(), pick(), pick(), "");
    // Random stream with gaps
    for (int k = 0; k < 400; k++)
      step(($urandom % 4) != 0, 1'($urandom), pick(), pick(), pick(), pick(), "");
    step(0, 0, '0, '0, '0, '0, "");
    step(0, 0, '0, '0, '0, '0, "");
    step(0, 0, '0, '0, '0, '0, "");
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL R7 watchdog expired: actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule